// File: doc/BRIEF.md
# Shared-Pin GPIO Expander Port

This block is a 16-pin general-purpose I/O port for a peripheral companion chip. Some of its pins can also be taken over by other functions, such as keypad scan lines or a buffered slow-clock output. The host configures the port through three registers, each loaded by a write on a byte-wide command/data stream:
- **Direction register.** Sets each pin to input or output.
- **Pull-select register.** Chooses whether a pin's weak pull device pulls up or pulls down.
- **State register.** Its meaning depends on the pin's direction. On an output pin it is the driven level. On an input pin it switches the weak pull device on.

A separate read path gives the synchronized live level of every pin, whatever its direction.

The block does not contain the host-bus protocol decoder or the keypad scanner. Another block owns those functions. It tells this port, through a per-pin claim mask, which pins it has taken. On a claimed pin the GPIO drive and pull are released, but the pin's level can still be read. A host gets open-drain behaviour on a pin by keeping its state bit at 0 and switching the pin between input and output.

Top module: `gpx_port`

## Requirements
- R1: After reset every pin is high-impedance: `pad_oe` and `pad_pull_en` are all zero until the host writes the registers.
- R2: A register write is one command byte (`wr_is_cmd`=1) followed by two data bytes. The first data byte loads pins 15..8 and the second loads pins 7..0. The new value is visible on the pad outputs in the cycle after the clock edge that accepts the second data byte, and not before. The command opcodes are 0xA1 (direction), 0xA2 (pull select) and 0xA3 (state).
- R3: In the direction register, 1 makes the pin an output. Writing 0x00 then 0x38 makes pins 3, 4 and 5 outputs and leaves all other pins as inputs.
- R4: An output pin drives its state bit on `pad_out` with its pull disabled. Clearing the direction bit of a pin whose state bit is 0 releases it, which gives open-drain use.
- R5: For an input pin:
  - the state bit drives `pad_pull_en`;
  - `pad_pull_up` then gives the pull-select bit (1 = pull up, 0 = pull down);
  - `pad_pull_up` is 0 whenever the pull is off.
- R6: `port_level` returns `pad_in` for all pins, inputs and outputs alike, SYNC_STAGES clock edges after the pad changes.
- R7: Pin 9 is input-only: its direction bit is ignored, so its `pad_oe` stays 0. Its state bit still acts as its pull enable.
- R8: While `slowclk_en` is 1, pin 3 is driven (`pad_oe[3]`=1, pull off) with `pad_out[3]` following `slowclk`, whatever the registers hold. When `slowclk_en` returns to 0, the register settings apply again.
- R9: A pin whose `claim_mask` bit is 1 has `pad_oe`, `pad_out`, `pad_pull_en` and `pad_pull_up` at 0, but its level still appears on `port_level`.
- R10: The registers keep their values in each of these cases:
  - a write cut short by a new command byte after only one data byte;
  - a write carrying an unknown opcode;
  - data bytes that follow no pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | A byte is presented this cycle |
| wr_is_cmd | input | 1 | 1: byte is a command opcode; 0: data byte |
| wr_byte | input | 8 | Command or data byte |
| claim_mask | input | 16 | 1 = pin taken by another function |
| slowclk_en | input | 1 | Route the slow clock onto pin 3 |
| slowclk | input | 1 | Slow clock to drive on pin 3 |
| pad_in | input | 16 | Level seen at each pin |
| pad_oe | output | 16 | Output enable per pin |
| pad_out | output | 16 | Driven level per pin |
| pad_pull_en | output | 16 | Weak pull device enable per pin |
| pad_pull_up | output | 16 | 1 = pull up, 0 = pull down |
| port_level | output | 16 | Synchronized pin levels |

## Verification
Some properties are checked by assertions on every cycle:
- a command byte never alters a register;
- pin 9 is never driven;
- no pin has both drive and pull enabled;
- claimed pins stay released;
- while enabled, the slow clock wins pin 3.

Other behaviour can only be shown by the bench scenarios, because it depends on what was written before:
- the byte order of a write and its exact cycle of effect;
- the dual meaning of the state bit;
- the pull direction;
- the read latency;
- the rejection of partial or unknown writes.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_DIR   = 2'd1,
        TGT_PULL  = 2'd2,
        TGT_STATE = 2'd3
    } gpx_tgt_e;

    localparam logic [7:0] OPC_DIR   = 8'hA1;
    localparam logic [7:0] OPC_PULL  = 8'hA2;
    localparam logic [7:0] OPC_STATE = 8'hA3;

    function automatic gpx_tgt_e decode_opc(input logic [7:0] opc);
        case (opc)
            OPC_DIR:   return TGT_DIR;
            OPC_PULL:  return TGT_PULL;
            OPC_STATE: return TGT_STATE;
            default:   return TGT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpx_reg_loader.sv
module gpx_reg_loader
    import gpx_pkg::*;
#(
    parameter int NPINS          = 16,
    parameter int INPUT_ONLY_PIN = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_is_cmd,
    input  logic [7:0]       wr_byte,
    output logic [NPINS-1:0] dir_o,
    output logic [NPINS-1:0] pull_o,
    output logic [NPINS-1:0] state_o
);
    localparam int NBYTES = NPINS / 8;
    localparam int CW     = (NBYTES > 2) ? $clog2(NBYTES) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(NBYTES - 1);
    localparam logic [NPINS-1:0] DIR_MASK = ~(NPINS'(1) << INPUT_ONLY_PIN);

    typedef struct packed {
        gpx_tgt_e         tgt;
        logic [CW-1:0]    cnt;
        logic [NPINS-1:0] acc;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] pull;
        logic [NPINS-1:0] state;
    } ld_t;

    ld_t ld_d, ld_q;
    logic [NPINS-1:0] word;

    always_comb begin
        ld_d = ld_q;
        word = {ld_q.acc[NPINS-9:0], wr_byte};
        if (wr_valid) begin
            if (wr_is_cmd) begin
                ld_d.tgt = decode_opc(wr_byte);
                ld_d.cnt = '0;
            end else if (ld_q.tgt != TGT_NONE) begin
                if (ld_q.cnt == LAST_IDX) begin
                    unique case (ld_q.tgt)
                        TGT_DIR:   ld_d.dir   = word & DIR_MASK;
                        TGT_PULL:  ld_d.pull  = word;
                        TGT_STATE: ld_d.state = word;
                        default:   ;
                    endcase
                    ld_d.tgt = TGT_NONE;
                    ld_d.cnt = '0;
                end else begin
                    ld_d.acc = word;
                    ld_d.cnt = ld_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q <= '{tgt: TGT_NONE, default: '0};
        end else begin
            ld_q <= ld_d;
        end
    end

    assign dir_o   = ld_q.dir;
    assign pull_o  = ld_q.pull;
    assign state_o = ld_q.state;

    // R10: a command byte only opens a write, it never changes a register
    assert_cmd_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_is_cmd) |=> ($stable(ld_q.dir) && $stable(ld_q.pull) && $stable(ld_q.state)));

    // R7: the input-only pin never holds an output direction
    assert_input_only_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_q.dir[INPUT_ONLY_PIN]);

endmodule

// File: rtl/gpx_pad_mux.sv
module gpx_pad_mux #(
    parameter int NPINS      = 16,
    parameter int CLKOUT_PIN = 3
) (
    input  logic [NPINS-1:0] dir_i,
    input  logic [NPINS-1:0] pull_i,
    input  logic [NPINS-1:0] state_i,
    input  logic [NPINS-1:0] claim_i,
    input  logic             slowclk_en_i,
    input  logic             slowclk_i,
    output logic [NPINS-1:0] oe_o,
    output logic [NPINS-1:0] out_o,
    output logic [NPINS-1:0] pull_en_o,
    output logic [NPINS-1:0] pull_up_o
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic gp_oe, gp_out, gp_pen, gp_pup;

        always_comb begin
            gp_oe  = 1'b0;
            gp_out = 1'b0;
            gp_pen = 1'b0;
            gp_pup = 1'b0;
            if (!claim_i[i]) begin
                if (dir_i[i]) begin
                    gp_oe  = 1'b1;
                    gp_out = state_i[i];
                end else begin
                    gp_pen = state_i[i];
                    gp_pup = state_i[i] & pull_i[i];
                end
            end
        end

        if (i == CLKOUT_PIN) begin : g_clk_pin
            always_comb begin
                oe_o[i]      = slowclk_en_i ? 1'b1 : gp_oe;
                out_o[i]     = slowclk_en_i ? slowclk_i : gp_out;
                pull_en_o[i] = slowclk_en_i ? 1'b0 : gp_pen;
                pull_up_o[i] = slowclk_en_i ? 1'b0 : gp_pup;
            end
        end else begin : g_plain_pin
            always_comb begin
                oe_o[i]      = gp_oe;
                out_o[i]     = gp_out;
                pull_en_o[i] = gp_pen;
                pull_up_o[i] = gp_pup;
            end
        end
    end

endmodule

// File: rtl/gpx_level_sync.sv
module gpx_level_sync #(
    parameter int NPINS  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_i,
    output logic [NPINS-1:0] level_o
);
    logic [STAGES-1:0][NPINS-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = pad_i;
        for (int s = 1; s < STAGES; s++) begin
            sync_d[s] = sync_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level_o = sync_q[STAGES-1];

endmodule

// File: rtl/gpx_port.sv
module gpx_port #(
    parameter int NPINS          = 16,
    parameter int INPUT_ONLY_PIN = 9,
    parameter int CLKOUT_PIN     = 3,
    parameter int SYNC_STAGES    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_is_cmd,
    input  logic [7:0]       wr_byte,
    input  logic [NPINS-1:0] claim_mask,
    input  logic             slowclk_en,
    input  logic             slowclk,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_pull_en,
    output logic [NPINS-1:0] pad_pull_up,
    output logic [NPINS-1:0] port_level
);
    logic [NPINS-1:0] dir_q, pull_q, state_q;
    logic [NPINS-1:0] free_mask;

    gpx_reg_loader #(
        .NPINS(NPINS), .INPUT_ONLY_PIN(INPUT_ONLY_PIN)
    ) u_loader (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_is_cmd(wr_is_cmd), .wr_byte(wr_byte),
        .dir_o(dir_q), .pull_o(pull_q), .state_o(state_q)
    );

    gpx_pad_mux #(
        .NPINS(NPINS), .CLKOUT_PIN(CLKOUT_PIN)
    ) u_mux (
        .dir_i(dir_q), .pull_i(pull_q), .state_i(state_q),
        .claim_i(claim_mask), .slowclk_en_i(slowclk_en), .slowclk_i(slowclk),
        .oe_o(pad_oe), .out_o(pad_out), .pull_en_o(pad_pull_en), .pull_up_o(pad_pull_up)
    );

    gpx_level_sync #(
        .NPINS(NPINS), .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_i(pad_in), .level_o(port_level)
    );

    always_comb begin
        free_mask = ~claim_mask;
        if (slowclk_en) begin
            free_mask[CLKOUT_PIN] = 1'b1;
        end
    end

    // R7: the input-only pin is never driven
    assert_pin_never_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[INPUT_ONLY_PIN]);

    // R4 / R5: a pin is either driven or pulled, never both
    assert_drive_pull_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pull_en) == '0);

    // R9: claimed pins (other than a slow-clock pin 3) are released by the GPIO logic
    assert_claimed_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_pull_en | pad_pull_up) & ~free_mask) == '0);

    // R8: the slow clock owns its pin while enabled
    assert_slowclk_owns_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slowclk_en |-> (pad_oe[CLKOUT_PIN] && (pad_out[CLKOUT_PIN] == slowclk) && !pad_pull_en[CLKOUT_PIN]));

endmodule

// File: tb/gpx_port_bench.sv
module gpx_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_is_cmd = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic [15:0] claim_mask = 16'h0000;
    logic        slowclk_en = 1'b0;
    logic        slowclk = 1'b0;
    logic [15:0] pad_in = 16'h0000;
    logic [15:0] pad_oe, pad_out, pad_pull_en, pad_pull_up, port_level;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpx_port u_gpx_port (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_is_cmd(wr_is_cmd), .wr_byte(wr_byte),
        .claim_mask(claim_mask), .slowclk_en(slowclk_en), .slowclk(slowclk),
        .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .port_level(port_level)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // presents one byte for one clock; returns at the following negedge
    task automatic put_byte(input logic is_cmd, input logic [7:0] b);
        wr_valid  = 1'b1;
        wr_is_cmd = is_cmd;
        wr_byte   = b;
        @(negedge clk);
        wr_valid  = 1'b0;
        wr_is_cmd = 1'b0;
        wr_byte   = 8'h00;
    endtask

    task automatic write_reg(input logic [7:0] opc, input logic [15:0] val);
        put_byte(1'b1, opc);
        put_byte(1'b0, val[15:8]);
        put_byte(1'b0, val[7:0]);
    endtask

    task automatic setup_regs(input logic [15:0] d, input logic [15:0] p, input logic [15:0] s);
        write_reg(8'hA1, d);
        write_reg(8'hA2, p);
        write_reg(8'hA3, s);
    endtask

    task automatic t_reset;
        chk("R1", "oe after reset", pad_oe, 16'h0000);
        chk("R1", "pull_en after reset", pad_pull_en, 16'h0000);
    endtask

    task automatic t_direction;
        setup_regs(16'h0000, 16'h0000, 16'h0030);
        write_reg(8'hA1, 16'h0038);
        chk("R3", "oe pins 3..5", pad_oe, 16'h0038);
        chk("R4", "driven levels", pad_out & pad_oe, 16'h0030);
        chk("R4", "no pull on outputs", pad_pull_en & 16'h0038, 16'h0000);
        // open drain on pin 3: state 0, toggle direction
        write_reg(8'hA1, 16'h0030);
        chk("R4", "pin3 released", {15'd0, pad_oe[3]}, 16'h0000);
        write_reg(8'hA1, 16'h0038);
        chk("R4", "pin3 drives low", {14'd0, pad_oe[3], pad_out[3]}, 16'h0002);
    endtask

    task automatic t_byte_order;
        setup_regs(16'h0000, 16'h0000, 16'h0000);
        put_byte(1'b1, 8'hA1);
        put_byte(1'b0, 8'h01);
        chk("R2", "no change before second byte", pad_oe, 16'h0000);
        put_byte(1'b0, 8'h80);
        chk("R2", "high byte then low byte", pad_oe, 16'h0180);
    endtask

    task automatic t_pull;
        setup_regs(16'h0038, 16'h8040, 16'hC0F0);
        chk("R5", "pull enables on inputs", pad_pull_en, 16'hC0C0);
        chk("R5", "pull directions", pad_pull_up, 16'h8040);
        chk("R4", "outputs keep levels", pad_out & pad_oe, 16'h0030);
    endtask

    task automatic t_input_only;
        setup_regs(16'h0000, 16'h0200, 16'h0000);
        write_reg(8'hA1, 16'h0200);
        chk("R7", "pin 9 not driven", pad_oe, 16'h0000);
        write_reg(8'hA3, 16'h0200);
        chk("R7", "pin 9 state is pull enable", pad_pull_en, 16'h0200);
        chk("R7", "pin 9 pulls up", pad_pull_up, 16'h0200);
    endtask

    task automatic t_read;
        setup_regs(16'h00FF, 16'h0000, 16'h0000);
        pad_in = 16'hA5C3;
        @(negedge clk);
        chk("R6", "one edge not yet visible", port_level, 16'h0000);
        @(negedge clk);
        chk("R6", "levels of inputs and outputs", port_level, 16'hA5C3);
        pad_in = 16'h3C5A;
        repeat (2) @(negedge clk);
        chk("R6", "second pattern", port_level, 16'h3C5A);
    endtask

    task automatic t_slowclk;
        setup_regs(16'h0000, 16'h0008, 16'h0008);
        slowclk_en = 1'b1;
        slowclk = 1'b1;
        @(negedge clk);
        chk("R8", "pin3 driven high", {14'd0, pad_oe[3], pad_out[3]}, 16'h0003);
        chk("R8", "pin3 pull off", {15'd0, pad_pull_en[3]}, 16'h0000);
        slowclk = 1'b0;
        @(negedge clk);
        chk("R8", "pin3 follows clock low", {14'd0, pad_oe[3], pad_out[3]}, 16'h0002);
        slowclk_en = 1'b0;
        @(negedge clk);
        chk("R8", "pin3 back to register", {14'd0, pad_oe[3], pad_pull_en[3]}, 16'h0001);
    endtask

    task automatic t_claim;
        setup_regs(16'hFFFF, 16'h0000, 16'hFFFF);
        claim_mask = 16'h00F0;
        @(negedge clk);
        chk("R9", "claimed pins not driven", pad_oe, 16'hFD0F);
        chk("R9", "claimed pins no pull", pad_pull_en & 16'h00F0, 16'h0000);
        chk("R9", "claimed pins out low", pad_out & 16'h00F0, 16'h0000);
        pad_in = 16'h0050;
        repeat (2) @(negedge clk);
        chk("R9", "claimed pins still read", port_level, 16'h0050);
        claim_mask = 16'h0000;
        @(negedge clk);
    endtask

    task automatic t_partial;
        setup_regs(16'h0011, 16'h0000, 16'h0000);
        put_byte(1'b1, 8'hA1);
        put_byte(1'b0, 8'hFF);
        put_byte(1'b1, 8'hA1);
        @(negedge clk);
        chk("R10", "cut-short write", pad_oe, 16'h0011);
        put_byte(1'b0, 8'hFF);
        put_byte(1'b0, 8'hFF);
        chk("R10", "restarted write still needs two bytes", pad_oe, 16'hFDFF);
        write_reg(8'hA1, 16'h0011);
        write_reg(8'h55, 16'hFFFF);
        chk("R10", "unknown opcode", pad_oe, 16'h0011);
        put_byte(1'b0, 8'hFF);
        put_byte(1'b0, 8'hFF);
        chk("R10", "stray data bytes", pad_oe, 16'h0011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_byte_order();
        t_pull();
        t_input_only();
        t_read();
        t_slowclk();
        t_claim();
        t_partial();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule